// File: doc/BRIEF.md
# Firmware Image Header Validator

This block screens a firmware image before any of it reaches non-volatile storage. The image enters one byte per transfer on a valid/ready stream, and a marker flags its final byte. While the bytes pass, the block captures the header fields it needs, counts the bytes and keeps a running byte sum. After the final byte it issues one verdict: a result code and a pass flag.

An operation opens with a one-cycle `start` pulse. The host supplies its own vendor and device identifiers on static inputs. The verdict stays on the outputs until the next accepted `start`. A `start` that arrives while an operation is still open is turned away, and the open operation runs on untouched.

Top module: `fw_image_validator`

## Requirements
- R1: While reset is low and after it, `result_code` is 0x000000, and `result_pass`, `result_done`, `s_ready`, `busy` and `refused` are all 0.
- R2: An accepted `start` sets `busy` and `s_ready` high from the next cycle on. From that cycle `result_code` reads 0x001000 (in progress) until the verdict appears.
- R3: Header fields are little-endian 32-bit words at fixed byte offsets: checksum at 32, vendor at 40, device at 44, sub-vendor at 48, sub-device at 52 and total length at 56. Bytes 0 to 31 (signature) and 36 to 39 are not examined. An image whose vendor and device words equal `host_vendor` and `host_device`, with correct length and checksum, yields code 0x000000 and pass 1.
- R4: The identity check also passes when the sub-vendor word equals `host_vendor` and the sub-device word equals `host_device`. A mix (vendor matched in one pair, device only in the other) fails with code 0x000200.
- R5: When the number of accepted bytes differs from the length word, the code is 0x000A00.
- R6: The checksum is the sum of every accepted byte, the checksum field's own bytes included, taken modulo 65536. It must equal the whole 32-bit checksum word, otherwise the code is 0x000300. A sum that passes 65535 wraps without error.
- R7: Checks rank identity first, then length, then checksum. The first failing check sets the code.
- R8: When the byte marked last is accepted on edge E, `s_ready` is low after E. At edge E+1 the verdict is written and `result_done` pulses high for one cycle.
- R9: A `start` while `busy` is high makes `refused` pulse one cycle later. The open operation continues and its verdict is unaffected.
- R10: The verdict (`result_code`, and `result_pass` equal to code == 0) holds until the next accepted `start`.
- R11: Byte order matters: identity words sent byte-reversed relative to the host IDs fail with 0x000200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin checking a new image |
| host_vendor | input | 32 | Vendor identifier of this host |
| host_device | input | 32 | Device identifier of this host |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of the image |
| s_ready | output | 1 | Block accepts a byte this cycle |
| busy | output | 1 | An operation is open |
| refused | output | 1 | Pulse: a start request was turned away |
| result_done | output | 1 | Pulse: verdict written this cycle |
| result_pass | output | 1 | Verdict is OK |
| result_code | output | 24 | Verdict or in-progress code |

## Verification
The hardest state to reach from the ports is a fully valid image, because the checksum field is counted in the sum it must match. The bench solves for this: it fills one signature byte and the checksum's second byte so that the field equals the wrapped total. With that in place, single faults (a shifted length word, one altered payload byte, a set upper checksum bit) and combined faults can be injected on top of an otherwise valid image. A long all-0xFF payload drives the sum past 16 bits.

// File: rtl/fwv_pkg.sv
// Shared constants for the firmware image validator.
// Assumes 32-bit header words placed on 4-byte aligned offsets.
package fwv_pkg;

    typedef logic [23:0] code_t;

    localparam code_t CODE_OK   = 24'h000000;
    localparam code_t CODE_ID   = 24'h000200;
    localparam code_t CODE_SUM  = 24'h000300;
    localparam code_t CODE_LEN  = 24'h000A00;
    localparam code_t CODE_BUSY = 24'h001000;

    // Captured header words, by index
    localparam int unsigned FIELD_N = 6;
    localparam int unsigned F_CHK   = 0;
    localparam int unsigned F_VEND  = 1;
    localparam int unsigned F_DEV   = 2;
    localparam int unsigned F_SVEND = 3;
    localparam int unsigned F_SDEV  = 4;
    localparam int unsigned F_LEN   = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RECV  = 2'd1,
        ST_JUDGE = 2'd2
    } state_t;

    // Byte offset of each captured word inside the header
    function automatic int unsigned fld_offset(input int unsigned idx);
        case (idx)
            0:       return 32;
            1:       return 40;
            2:       return 44;
            3:       return 48;
            4:       return 52;
            default: return 56;
        endcase
    endfunction

endpackage

// File: rtl/fwv_hdr_capture.sv
// Captures the little-endian header words as bytes stream past.
// Assumes each word offset is a multiple of the word size in bytes.
module fwv_hdr_capture
    import fwv_pkg::*;
#(
    parameter int unsigned FIELD_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clear,
    input  logic                            beat,
    input  logic [FIELD_W-1:0]              byte_idx,
    input  logic [7:0]                      data,
    output logic [FIELD_N-1:0][FIELD_W-1:0] fields
);
    localparam int unsigned NBYTES = FIELD_W / 8;
    localparam int unsigned LANE_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    genvar g;
    generate
        for (g = 0; g < FIELD_N; g++) begin : g_field
            localparam int unsigned OFF = fld_offset(g);
            logic [FIELD_W-1:0] word_q;
            logic               hit;
            logic [LANE_W-1:0]  lane;

            // Byte lands in this word when its index falls in the word's window
            always_comb begin
                hit  = beat && (byte_idx >= FIELD_W'(OFF)) &&
                       (byte_idx < FIELD_W'(OFF + NBYTES));
                lane = byte_idx[LANE_W-1:0];
            end

            // Store the byte into its lane, low lane first
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    word_q <= '0;
                end else if (hit) begin
                    word_q[lane*8 +: 8] <= data;
                end
            end

            assign fields[g] = word_q;
        end
    endgenerate

endmodule

// File: rtl/fwv_sum_count.sv
// Counts accepted bytes and keeps their sum modulo 2**KEEP_W.
// Assumes the counter does not wrap within one image.
module fwv_sum_count #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned KEEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              beat,
    input  logic [7:0]        data,
    output logic [CNT_W-1:0]  count,
    output logic [KEEP_W-1:0] sum
);
    // Advance count and sum on each accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
            sum   <= '0;
        end else if (beat) begin
            count <= count + 1'b1;
            sum   <= sum + KEEP_W'(data);
        end
    end

endmodule

// File: rtl/fwv_verdict.sv
// Combines identity, length and checksum tests into one ranked code.
// Assumes all inputs are stable in the judging cycle.
module fwv_verdict
    import fwv_pkg::*;
#(
    parameter int unsigned FIELD_W = 32,
    parameter int unsigned KEEP_W  = 16
) (
    input  logic [FIELD_N-1:0][FIELD_W-1:0] fields,
    input  logic [FIELD_W-1:0]              host_vendor,
    input  logic [FIELD_W-1:0]              host_device,
    input  logic [FIELD_W-1:0]              count,
    input  logic [KEEP_W-1:0]               sum,
    output code_t                           code,
    output logic                            pass
);
    logic prim_ok, sub_ok, len_ok, sum_ok;

    // Individual tests
    always_comb begin
        prim_ok = (fields[F_VEND] == host_vendor) && (fields[F_DEV] == host_device);
        sub_ok  = (fields[F_SVEND] == host_vendor) && (fields[F_SDEV] == host_device);
        len_ok  = (fields[F_LEN] == count);
        sum_ok  = (fields[F_CHK] == FIELD_W'(sum));
    end

    // Ranked selection: identity, then length, then checksum
    always_comb begin
        if (!(prim_ok || sub_ok)) begin
            code = CODE_ID;
        end else if (!len_ok) begin
            code = CODE_LEN;
        end else if (!sum_ok) begin
            code = CODE_SUM;
        end else begin
            code = CODE_OK;
        end
        pass = (prim_ok || sub_ok) && len_ok && sum_ok;
    end

endmodule

// File: rtl/fw_image_validator.sv
// Top of the firmware image validator: sequences one check per start.
// Assumes host IDs stay stable during an operation.
module fw_image_validator
    import fwv_pkg::*;
#(
    parameter int unsigned FIELD_W = 32,
    parameter int unsigned KEEP_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FIELD_W-1:0] host_vendor,
    input  logic [FIELD_W-1:0] host_device,
    input  logic               s_valid,
    input  logic [7:0]         s_data,
    input  logic               s_last,
    output logic               s_ready,
    output logic               busy,
    output logic               refused,
    output logic               result_done,
    output logic               result_pass,
    output logic [23:0]        result_code
);
    state_t                          state;
    logic                            beat, clear;
    logic [FIELD_N-1:0][FIELD_W-1:0] fields;
    logic [FIELD_W-1:0]              count;
    logic [KEEP_W-1:0]               sum;
    code_t                           v_code;
    logic                            v_pass;

    // Handshake and clear decode from current state
    always_comb begin
        s_ready = (state == ST_RECV);
        busy    = (state != ST_IDLE);
        beat    = s_valid && s_ready;
        clear   = (state == ST_IDLE) && start;
    end

    fwv_hdr_capture #(.FIELD_W(FIELD_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(clear), .beat(beat),
        .byte_idx(count), .data(s_data), .fields(fields)
    );

    fwv_sum_count #(.CNT_W(FIELD_W), .KEEP_W(KEEP_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(clear), .beat(beat),
        .data(s_data), .count(count), .sum(sum)
    );

    fwv_verdict #(.FIELD_W(FIELD_W), .KEEP_W(KEEP_W)) u_ver (
        .fields(fields), .host_vendor(host_vendor), .host_device(host_device),
        .count(count), .sum(sum), .code(v_code), .pass(v_pass)
    );

    // Operation sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            result_code <= CODE_OK;
            result_pass <= 1'b0;
            result_done <= 1'b0;
            refused     <= 1'b0;
        end else begin
            result_done <= 1'b0;
            refused     <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state       <= ST_RECV;
                        result_code <= CODE_BUSY;
                        result_pass <= 1'b0;
                    end
                end
                ST_RECV: begin
                    if (start) refused <= 1'b1;
                    if (beat && s_last) state <= ST_JUDGE;
                end
                ST_JUDGE: begin
                    if (start) refused <= 1'b1;
                    state       <= ST_IDLE;
                    result_code <= v_code;
                    result_pass <= v_pass;
                    result_done <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fwv_checker.sv
// Temporal checks on the validator's ports, attached by bind.
module fwv_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        s_valid,
    input logic        s_last,
    input logic        s_ready,
    input logic        busy,
    input logic        refused,
    input logic        result_done,
    input logic        result_pass,
    input logic [23:0] result_code
);
    assert_last_then_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_last) |=> (!s_ready && !result_done) ##1 result_done);

    assert_inprogress_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (result_code == 24'h001000));

    assert_refuse_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> refused);

    assert_pass_matches_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        result_done |-> (result_pass == (result_code == 24'h0)));

    assert_verdict_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(start)) |-> $stable(result_code));

    assert_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_done |-> (result_code == 24'h0 || result_code == 24'h000200 ||
                         result_code == 24'h000300 || result_code == 24'h000A00));
endmodule

bind fw_image_validator fwv_checker u_fwv_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid),
    .s_last(s_last), .s_ready(s_ready), .busy(busy), .refused(refused),
    .result_done(result_done), .result_pass(result_pass),
    .result_code(result_code)
);

// File: tb/fw_image_validator_test.sv
module fw_image_validator_test;
    localparam logic [31:0] HV = 32'h1122_9005;
    localparam logic [31:0] HD = 32'h0410_A3B7;

    typedef struct packed {
        logic [31:0]       hv;
        logic [31:0]       hd;
        logic [31:0]       sv;
        logic [31:0]       sd;
        logic signed [7:0] ld;
        logic              cor;
        logic              hi;
        logic [15:0]       npay;
        logic [7:0]        fill;
        logic              gaps;
        logic [23:0]       exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{HV, HD, 32'h0, 32'h0,  8'sd0, 1'b0, 1'b0, 16'd20,  8'h00, 1'b0, 24'h000000}, // R3
        '{32'hDEAD0001, HD, HV, HD, 8'sd0, 1'b0, 1'b0, 16'd24, 8'h00, 1'b1, 24'h000000}, // R4
        '{HV, 32'h0, 32'h5, HD,  8'sd0, 1'b0, 1'b0, 16'd8,   8'h00, 1'b0, 24'h000200}, // R4 mix
        '{HD, HV, HD, HV,        8'sd0, 1'b0, 1'b0, 16'd8,   8'h00, 1'b0, 24'h000200}, // R4 swap
        '{HV, HD, 32'h0, 32'h0,  8'sd1, 1'b0, 1'b0, 16'd10,  8'h00, 1'b0, 24'h000A00}, // R5
        '{HV, HD, 32'h0, 32'h0, -8'sd1, 1'b0, 1'b0, 16'd10,  8'h00, 1'b1, 24'h000A00}, // R5
        '{HV, HD, 32'h0, 32'h0,  8'sd0, 1'b1, 1'b0, 16'd12,  8'h00, 1'b0, 24'h000300}, // R6
        '{32'h7, HD, 32'h0, 32'h0, 8'sd2, 1'b1, 1'b0, 16'd12, 8'h00, 1'b0, 24'h000200}, // R7
        '{HV, HD, 32'h0, 32'h0, -8'sd3, 1'b1, 1'b0, 16'd12,  8'h00, 1'b0, 24'h000A00}, // R7
        '{HV, HD, 32'h0, 32'h0,  8'sd0, 1'b0, 1'b0, 16'd280, 8'hFF, 1'b0, 24'h000000}, // R6 wrap
        '{HV, HD, 32'h0, 32'h0,  8'sd0, 1'b0, 1'b1, 16'd6,   8'h00, 1'b0, 24'h000300}, // R6 hi
        '{32'h0590_2211, 32'hB7A3_1004, 32'h0, 32'h0, 8'sd0, 1'b0, 1'b0, 16'd6, 8'h00, 1'b0, 24'h000200} // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = 8'h0;
    logic        s_last = 1'b0;
    logic        s_ready, busy, refused, result_done, result_pass;
    logic [23:0] result_code;

    int checks = 0;
    int errors = 0;
    logic [7:0] img [512];
    int img_n;

    always #10 clk = ~clk;

    fw_image_validator uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .host_vendor(HV), .host_device(HD),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_ready(s_ready), .busy(busy), .refused(refused),
        .result_done(result_done), .result_pass(result_pass),
        .result_code(result_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put32(input int off, input logic [31:0] w);
        for (int b = 0; b < 4; b++) img[off+b] = w[b*8 +: 8];
    endtask

    // Build an image whose checksum field matches the wrapped byte sum
    task automatic build(input vec_t v);
        int s, p, c1;
        img_n = 60 + int'(v.npay);
        for (int i = 0; i < 512; i++) img[i] = 8'h00;
        for (int i = 1; i < 32; i++) img[i] = 8'((i * 7 + 3) & 255);
        put32(36, 32'hFFFF_FFFF);
        put32(40, v.hv);
        put32(44, v.hd);
        put32(48, v.sv);
        put32(52, v.sd);
        put32(56, 32'(img_n + int'(v.ld)));
        for (int k = 0; k < int'(v.npay); k++)
            img[60+k] = (v.fill != 0) ? v.fill : 8'((k * 13 + 5) & 255);
        s = 0;
        for (int i = 0; i < img_n; i++) s += int'(img[i]);
        s = s % 65536;
        p = (255 - (s % 255)) % 255;
        c1 = (s + p) / 255;
        img[0]  = 8'(p);
        img[32] = 8'h5A;
        img[33] = 8'(c1);
        if (v.cor) img[60] = img[60] + 8'd1;
        if (v.hi)  img[34] = 8'h01;
    endtask

    task automatic pulse_start;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R2 busy", {31'b0, busy}, 32'd1);
        chk("R2 ready", {31'b0, s_ready}, 32'd1);
        chk("R2 code", {8'b0, result_code}, 32'h001000);
    endtask

    // Stream the image; optional idle gaps and a refused start at index rf
    task automatic send(input bit gaps, input int rf, input logic [23:0] exp);
        logic rdy;
        for (int i = 0; i < img_n; i++) begin
            if (gaps && (i % 3 == 1)) @(negedge clk);
            s_valid = 1'b1;
            s_data  = img[i];
            s_last  = (i == img_n - 1);
            start   = (i == rf);
            forever begin
                rdy = s_ready;
                @(negedge clk);
                start = 1'b0;
                if (i == rf) chk("R9 refused pulse", {31'b0, refused}, 32'd1);
                if (rdy) break;
            end
            s_valid = 1'b0;
            s_last  = 1'b0;
        end
        chk("R8 ready low after last", {31'b0, s_ready}, 32'd0);
        chk("R8 no early verdict", {31'b0, result_done}, 32'd0);
        @(negedge clk);
        chk("R8 done pulse", {31'b0, result_done}, 32'd1);
        chk("R7 result code", {8'b0, result_code}, {8'b0, exp});
        chk("R10 pass flag", {31'b0, result_pass}, {31'b0, (exp == 24'h0)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 code", {8'b0, result_code}, 32'h0);
        chk("R1 ready", {31'b0, s_ready}, 32'd0);
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 pass", {31'b0, result_pass}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", {31'b0, result_done}, 32'd0);
        chk("R1 refused", {31'b0, refused}, 32'd0);

        // Table of vectors (R3..R7, R11)
        for (int n = 0; n < NV; n++) begin
            build(VECS[n]);
            pulse_start();
            send(VECS[n].gaps, -1, VECS[n].exp);
        end

        // R10: verdict held while idle
        repeat (5) @(negedge clk);
        chk("R10 hold code", {8'b0, result_code}, 32'h000200);
        chk("R10 done low", {31'b0, result_done}, 32'd0);

        // R9: start during transfer refused, operation unaffected
        build(VECS[0]);
        pulse_start();
        send(1'b0, 17, 24'h000000);

        // R10: next start replaces verdict with in-progress
        build(VECS[6]);
        pulse_start();
        chk("R10 cleared pass", {31'b0, result_pass}, 32'd0);
        send(1'b0, -1, 24'h000300);

        // R1: reset in the middle of a transfer
        build(VECS[0]);
        pulse_start();
        @(negedge clk) begin s_valid = 1'b1; s_data = 8'h11; end
        @(negedge clk) begin s_valid = 1'b0; rst_n = 1'b0; end
        @(negedge clk);
        chk("R1 mid reset busy", {31'b0, busy}, 32'd0);
        chk("R1 mid reset code", {8'b0, result_code}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        pulse_start();
        send(1'b0, -1, 24'h000000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule